// File: doc/BRIEF.md
# Gated Sample Capture Controller

This block sits between a free-running sample source and the write port of a capture memory. It watches a gate input, already synchronized to the sample clock, and lets through only the samples that fall inside a gate window. Four gate modes are offered. Two are edge-opened. Two open only after the gate input has held a qualifying level for longer than a programmed number of samples. In every mode the window closes on the opposite edge of the gate input.

Closing is not immediate. Capture memory is written in groups of eight samples, so a close request takes effect only after the sample that completes the current group has been recorded. Up to seven samples beyond the closing edge are therefore written. Each window then starts on a group-aligned index. The block also drives a running write index and a window-active flag.

The sample stream is valid-only on both sides. The source offers one sample per cycle in which `s_valid` is high, and the block never applies back-pressure. The memory side must accept every cycle in which `m_valid` is high. No sample is buffered, and no sample is delayed.

Top module: `gated_capture`

## Requirements
- R1: With `mode` = 0 (rising), a window opens on a valid sample whose gate level is 1 when the previous valid sample's level was 0, and a close is requested on a valid sample with level 0 after a level-1 sample.
- R2: With `mode` = 1 (falling), a window opens on a 1-to-0 change of the gate level between consecutive valid samples, and a close is requested on a 0-to-1 change.
- R3: With `mode` = 2 (high pulse), a run counter counts consecutive valid samples at the same gate level, starting at 1 on a level change. A window opens on the first sample at level 1 whose run count is strictly greater than `pulse_thresh`. A close is requested on the next 1-to-0 change.
- R4: With `mode` = 3 (low pulse), the same rule as R3 applies with the levels swapped. A close is requested on the next 0-to-1 change.
- R5: The sample that opens a window and the sample that requests a close are both recorded. After a close request, recording continues until a sample whose index modulo 8 equals 7 has been recorded, and then it stops.
- R6: A close request is held until the group boundary, even if the gate returns to its opening level. A new window can open only on a sample after the block has paused.
- R7: A sample is written (`m_valid` = 1) in the same cycle as `s_valid`, only while a window is open, with `m_data` equal to `s_data`.
- R8: `m_index` is 0 while `en` is low. It shows the index of the sample being written, advances by one after each write, and holds otherwise, so each window starts at a multiple of 8.
- R9: `gate_active` is high from the opening sample through the last recorded sample of the final group, and low while the block is paused.
- R10: Deasserting `en` abandons any window at once, blocks writes, and forgets the gate history. The first valid sample after re-enabling only records the gate level and produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Capture enable; low clears index and window state |
| mode | input | 2 | Gate mode: 0 rising, 1 falling, 2 high pulse, 3 low pulse |
| pulse_thresh | input | PW_W | Pulse qualification threshold in samples |
| gate_in | input | 1 | Synchronized gate level |
| s_valid | input | 1 | Incoming sample strobe |
| s_data | input | DATA_W | Incoming sample word |
| m_valid | output | 1 | Memory write strobe |
| m_data | output | DATA_W | Word to write |
| m_index | output | IDX_W | Index of the sample being written |
| gate_active | output | 1 | Capture window (including drain) is active |

## Verification
The assertions assume that `mode` and `pulse_thresh` stay constant while `en` is high. They also assume that `gate_in` and `s_data` are meaningful only in cycles where `s_valid` is high. The bench respects these assumptions. It changes `mode` and the threshold only inside a phase where `en` is low. It drives the gate level together with each sample on the falling clock edge. It inserts gaps with `s_valid` low so that the index and window state are seen to hold.

// File: rtl/gcap_pkg.sv
package gcap_pkg;

  typedef enum logic [1:0] {
    GM_RISE       = 2'd0,
    GM_FALL       = 2'd1,
    GM_HIGH_PULSE = 2'd2,
    GM_LOW_PULSE  = 2'd3
  } gate_mode_e;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_OPEN  = 2'd1,
    GS_DRAIN = 2'd2
  } gate_state_e;

endpackage

// File: rtl/gcap_qualifier.sv
module gcap_qualifier
  import gcap_pkg::*;
#(
  parameter int PW_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      mode,
  input  logic [PW_W-1:0] pulse_thresh,
  input  logic            gate_in,
  input  logic            s_valid,
  output logic            start_evt,
  output logic            end_evt
);

  localparam int RUN_W = PW_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             lvl_prev;
  logic             primed;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_now;
  logic             sample;
  logic             same_lvl;
  logic             rise, fall;
  logic             run_over;
  gate_mode_e       gmode;

  assign gmode    = gate_mode_e'(mode);
  assign sample   = en & s_valid;
  assign same_lvl = primed & (gate_in == lvl_prev);

  // Length of the current constant-level run, this sample included.
  always_comb begin
    if (!same_lvl)            run_now = RUN_W'(1);
    else if (run_q == RUN_MAX) run_now = run_q;
    else                      run_now = run_q + RUN_W'(1);
  end

  assign run_over = run_now > {1'b0, pulse_thresh};
  assign rise     = sample & primed & ~lvl_prev & gate_in;
  assign fall     = sample & primed & lvl_prev & ~gate_in;

  always_comb begin
    start_evt = 1'b0;
    end_evt   = 1'b0;
    case (gmode)
      GM_RISE: begin
        start_evt = rise;
        end_evt   = fall;
      end
      GM_FALL: begin
        start_evt = fall;
        end_evt   = rise;
      end
      GM_HIGH_PULSE: begin
        start_evt = sample & gate_in & run_over;
        end_evt   = fall;
      end
      GM_LOW_PULSE: begin
        start_evt = sample & ~gate_in & run_over;
        end_evt   = rise;
      end
      default: begin
        start_evt = 1'b0;
        end_evt   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= 1'b0;
      primed   <= 1'b0;
      run_q    <= '0;
    end else if (!en) begin
      primed   <= 1'b0;
      run_q    <= '0;
    end else if (s_valid) begin
      lvl_prev <= gate_in;
      primed   <= 1'b1;
      run_q    <= run_now;
    end
  end

  // R3: a nonzero threshold can only be exceeded after earlier high samples
  p_pulse_history_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && gmode == GM_HIGH_PULSE && start_evt && pulse_thresh != '0)
      |-> (primed && lvl_prev));

  // R10: a freshly enabled block reports no edge on its first sample
  p_no_edge_unprimed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (!(rise || fall)));

endmodule

// File: rtl/gcap_window_fsm.sv
module gcap_window_fsm
  import gcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic s_valid,
  input  logic start_evt,
  input  logic end_evt,
  input  logic group_last,
  output logic rec,
  output logic active
);

  gate_state_e st_q, st_d;
  logic        sample;
  logic        start_hit;

  assign sample    = en & s_valid;
  assign start_hit = (st_q == GS_IDLE) & sample & start_evt;
  assign rec       = start_hit | (sample & (st_q != GS_IDLE));
  assign active    = start_hit | (st_q != GS_IDLE);

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = GS_IDLE;
    end else begin
      case (st_q)
        GS_IDLE:  if (start_hit) st_d = GS_OPEN;
        GS_OPEN:  if (sample && end_evt) st_d = group_last ? GS_IDLE : GS_DRAIN;
        GS_DRAIN: if (sample && group_last) st_d = GS_IDLE;
        default:  st_d = GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_IDLE;
    else        st_q <= st_d;
  end

  // R5: while enabled, a window only ends after a group-closing sample
  p_close_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != GS_IDLE && en && !(s_valid && group_last)) |=> (st_q != GS_IDLE));

  // R6: a pending close is never cancelled back to an open window
  p_drain_no_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_DRAIN) |=> (st_q != GS_OPEN));

  // R10: disabling always returns to the paused state
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (st_q == GS_IDLE));

endmodule

// File: rtl/gcap_indexer.sv
module gcap_indexer #(
  parameter int IDX_W      = 16,
  parameter int GROUP_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rec,
  output logic [IDX_W-1:0] idx,
  output logic             group_last
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (!en) idx_q <= '0;
    else if (rec) idx_q <= idx_q + IDX_W'(1);
  end

  assign idx = idx_q;

  generate
    if (GROUP_BITS == 0) begin : g_single
      assign group_last = 1'b1;
    end else begin : g_multi
      assign group_last = &idx_q[GROUP_BITS-1:0];
    end
  endgenerate

  // R8: index holds when nothing is written
  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rec) |=> $stable(idx_q));

  // R8: index is cleared while disabled
  p_idx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (idx_q == '0));

endmodule

// File: rtl/gated_capture.sv
module gated_capture #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 16,
  parameter int PW_W   = 12,
  parameter int GROUP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [PW_W-1:0]   pulse_thresh,
  input  logic              gate_in,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [IDX_W-1:0]  m_index,
  output logic              gate_active
);

  localparam int GROUP_BITS = $clog2(GROUP);

  logic start_evt, end_evt;
  logic rec, group_last;

  gcap_qualifier #(.PW_W(PW_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .pulse_thresh(pulse_thresh), .gate_in(gate_in), .s_valid(s_valid),
    .start_evt(start_evt), .end_evt(end_evt)
  );

  gcap_window_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .s_valid(s_valid),
    .start_evt(start_evt), .end_evt(end_evt), .group_last(group_last),
    .rec(rec), .active(gate_active)
  );

  gcap_indexer #(.IDX_W(IDX_W), .GROUP_BITS(GROUP_BITS)) u_idx (
    .clk(clk), .rst_n(rst_n), .en(en), .rec(rec),
    .idx(m_index), .group_last(group_last)
  );

  assign m_valid = rec;
  assign m_data  = s_data;

  // R7: a write needs an offered sample and an enabled block
  p_write_needs_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (s_valid && en));

  // R9: writes only happen inside an active window
  p_write_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> gate_active);

  generate
    if (GROUP_BITS > 0) begin : g_align_chk
      // R8: a paused block always sits on a group-aligned index
      p_idle_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_active) |-> (m_index[GROUP_BITS-1:0] == '0));
    end
  endgenerate

endmodule

// File: tb/gated_capture_test.sv
module gated_capture_test;

  localparam int DATA_W = 16;
  localparam int IDX_W  = 16;
  localparam int PW_W   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic [PW_W-1:0]   pulse_thresh = '0;
  logic              gate_in = 1'b0;
  logic              s_valid = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic              m_valid;
  logic [DATA_W-1:0] m_data;
  logic [IDX_W-1:0]  m_index;
  logic              gate_active;

  int checks = 0;
  int failures = 0;
  int dcount = 100;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gated_capture #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PW_W(PW_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pulse_thresh(pulse_thresh),
    .gate_in(gate_in), .s_valid(s_valid), .s_data(s_data),
    .m_valid(m_valid), .m_data(m_data), .m_index(m_index), .gate_active(gate_active)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One valid sample; checks write strobe, window flag, data and index.
  task automatic send(input logic g, input logic w, input int ix, input string tag);
    @(negedge clk);
    s_valid = 1'b1;
    gate_in = g;
    s_data  = DATA_W'(dcount);
    #1;
    check(m_valid == w, {tag, " m_valid"}, int'(m_valid), int'(w));
    check(gate_active == w, {tag, " gate_active R9"}, int'(gate_active), int'(w));
    if (w) begin
      check(m_data == DATA_W'(dcount), {tag, " m_data R7"}, int'(m_data), dcount);
      check(m_index == IDX_W'(ix), {tag, " m_index R8"}, int'(m_index), ix);
    end
    dcount++;
  endtask

  task automatic quiet(input int n, input int ix, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b0;
      #1;
      check(m_valid == 1'b0, {tag, " no write without s_valid R7"}, int'(m_valid), 0);
      check(m_index == IDX_W'(ix), {tag, " index holds R8"}, int'(m_index), ix);
    end
  endtask

  task automatic restart(input logic [1:0] md, input int thr);
    @(negedge clk);
    en = 1'b0;
    s_valid = 1'b0;
    mode = md;
    pulse_thresh = PW_W'(thr);
    @(negedge clk);
    #1;
    check(m_index == '0, "index cleared while disabled R8", int'(m_index), 0);
    check(gate_active == 1'b0, "paused while disabled R10", int'(gate_active), 0);
    en = 1'b1;
  endtask

  task automatic t_reset;
    #1;
    check(m_valid == 1'b0, "reset m_valid R7", int'(m_valid), 0);
    check(gate_active == 1'b0, "reset gate_active R9", int'(gate_active), 0);
    check(m_index == '0, "reset m_index R8", int'(m_index), 0);
  endtask

  task automatic t_rise_drain;
    restart(2'd0, 0);
    for (int i = 0; i < 3; i++) send(1'b0, 1'b0, 0, "R1 low before edge");
    send(1'b1, 1'b1, 0, "R1 rising opens");
    for (int i = 1; i < 5; i++) send(1'b1, 1'b1, i, "R1 open");
    quiet(2, 5, "R8 gap");
    for (int i = 5; i < 10; i++) send(1'b1, 1'b1, i, "R1 open after gap");
    send(1'b0, 1'b1, 10, "R5 falling edge recorded");
    for (int i = 11; i < 16; i++) send(1'b0, 1'b1, i, "R5 drain to boundary");
    send(1'b0, 1'b0, 0, "R5 paused after index 15");
    check(m_index == 16, "R8 index after window", int'(m_index), 16);
  endtask

  task automatic t_fall_aligned;
    restart(2'd1, 0);
    send(1'b1, 1'b0, 0, "R2 high before edge");
    send(1'b1, 1'b0, 0, "R2 high before edge");
    send(1'b0, 1'b1, 0, "R2 falling opens");
    for (int i = 1; i < 7; i++) send(1'b0, 1'b1, i, "R2 open");
    send(1'b1, 1'b1, 7, "R5 close at index 7");
    send(1'b1, 1'b0, 0, "R5 no extra after aligned close");
    send(1'b0, 1'b1, 8, "R6 reopen after pause");
    send(1'b0, 1'b1, 9, "R2 reopened window");
  endtask

  task automatic t_high_pulse;
    restart(2'd2, 3);
    send(1'b0, 1'b0, 0, "R3 low");
    for (int i = 0; i < 3; i++) send(1'b1, 1'b0, 0, "R3 short pulse");
    send(1'b0, 1'b0, 0, "R3 short pulse ignored");
    for (int i = 0; i < 3; i++) send(1'b1, 1'b0, 0, "R3 run not above threshold");
    send(1'b1, 1'b1, 0, "R3 run 4 above threshold 3");
    send(1'b1, 1'b1, 1, "R3 open");
    send(1'b1, 1'b1, 2, "R3 open");
    send(1'b0, 1'b1, 3, "R3 falling end recorded");
    for (int i = 4; i < 8; i++) send(1'b0, 1'b1, i, "R5 drain");
    send(1'b0, 1'b0, 0, "R3 paused");
    restart(2'd2, 0);
    send(1'b1, 1'b1, 0, "R3 threshold 0 opens at once");
  endtask

  task automatic t_low_pulse_pending;
    restart(2'd3, 1);
    send(1'b1, 1'b0, 0, "R4 high");
    send(1'b0, 1'b0, 0, "R4 run 1 not above 1");
    send(1'b0, 1'b1, 0, "R4 run 2 opens");
    send(1'b1, 1'b1, 1, "R4 rising end recorded");
    send(1'b0, 1'b1, 2, "R6 reassert low keeps drain");
    send(1'b0, 1'b1, 3, "R6 drain");
    send(1'b0, 1'b1, 4, "R6 drain");
    send(1'b1, 1'b1, 5, "R6 drain");
    send(1'b1, 1'b1, 6, "R6 drain");
    send(1'b1, 1'b1, 7, "R6 last of group");
    send(1'b1, 1'b0, 0, "R6 pending close honoured");
    send(1'b1, 1'b0, 0, "R4 high does not qualify");
  endtask

  task automatic t_abort;
    restart(2'd0, 0);
    send(1'b0, 1'b0, 0, "R10 low");
    send(1'b1, 1'b1, 0, "R10 open");
    send(1'b1, 1'b1, 1, "R10 open");
    @(negedge clk);
    en = 1'b0;
    s_valid = 1'b1;
    gate_in = 1'b1;
    #1;
    check(m_valid == 1'b0, "R10 no write when disabled", int'(m_valid), 0);
    @(negedge clk);
    #1;
    check(gate_active == 1'b0, "R10 window abandoned", int'(gate_active), 0);
    check(m_index == '0, "R10 index cleared", int'(m_index), 0);
    en = 1'b1;
    send(1'b1, 1'b0, 0, "R10 first sample only primes");
    send(1'b1, 1'b0, 0, "R10 no edge at constant level");
    send(1'b0, 1'b0, 0, "R10 falling ignored in rising mode");
    send(1'b1, 1'b1, 0, "R10 real edge opens");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_rise_drain();
    t_fall_aligned();
    t_high_pulse();
    t_low_pulse_pending();
    t_abort();
    @(negedge clk);
    s_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule